// File: doc/BRIEF.md
# Serial EEPROM Bus Slave Front End

This block is the bit-level two-wire bus slave for a 2048-byte serial memory. It watches the already synchronised clock and data lines and detects START and STOP. It shifts in the device byte and decides whether to acknowledge it. It then builds an 11-bit memory address: three bits come from the device byte and eight from a following word-address byte. Data bytes received during a write go to a write engine as single-cycle strobes. During a read, the block fetches bytes from the array through a combinational read port and shifts them out MSB first.

The acknowledge policy depends on two inputs from the rest of the chip. While the write engine reports a programming cycle in progress, the device byte is not acknowledged. While the write-protect input is high, the device byte and word address are still acknowledged, but data bytes are refused and nothing is stored. When a STOP ends a write that stored at least one byte, the block pulses a commit strobe so the write engine can start programming.

Top module: `ee_i2c_front`

## Requirements
- R1: A device byte whose upper four bits are not 4'b1010 is not acknowledged, and the block ignores the bus until the next START.
- R2: While busy_i is high at the end of the device byte, the device byte is not acknowledged.
- R3: Device byte bit 0 selects the direction (1 read, 0 write). Bits 3:1 are loaded into memory address bits 10:8 when the device byte is acknowledged.
- R4: In a write, the byte after the device byte is acknowledged and is loaded into memory address bits 7:0.
- R5: Each later write data byte is acknowledged and produces one wr_valid_o pulse, with wr_addr_o equal to the current address and wr_data_o equal to the byte.
- R6: After each stored write byte, only address bits 4:0 increment, wrapping inside the 32-byte page. Bits 10:5 stay unchanged.
- R7: With wp_i high, the device and word-address bytes are acknowledged, but data bytes are not acknowledged, produce no wr_valid_o and do not advance the address.
- R8: Read data is shifted out MSB first from rd_data_i at rd_addr_o. The full 11-bit address increments after each byte, wrapping from 0x7FF to 0x000 and crossing blocks.
- R9: A master NACK after a read byte ends the transfer, and SDA is released before the next START or STOP.
- R10: A STOP pulses wr_commit_o for one cycle if at least one byte was stored since the previous STOP; otherwise it does not.
- R11: A START or STOP at any point restarts device-byte reception or returns to idle. A partially received byte is discarded and leaves the address unchanged.
- R12: sda_oe_o changes only while SCL is low.
- R13: After reset, SDA is released and wr_valid_o and wr_commit_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised bus clock |
| sda_i | input | 1 | Synchronised bus data (wired level) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| busy_i | input | 1 | Programming cycle in progress |
| wp_i | input | 1 | Write protect, high refuses data |
| wr_valid_o | output | 1 | Write byte strobe |
| wr_addr_o | output | 11 | Address of strobed write byte |
| wr_data_o | output | 8 | Strobed write byte |
| wr_commit_o | output | 1 | Start programming pulse at STOP |
| rd_en_o | output | 1 | Pulse when a read byte is fetched |
| rd_addr_o | output | 11 | Current memory address |
| rd_data_i | input | 8 | Array data at rd_addr_o |

## Verification
The hardest case to reach is a START or STOP that arrives after only part of a data byte has been shifted in. To get there, the bench has its own bit-level task that clocks out a chosen number of data bits and then issues the condition. A later read then shows that the address did not move and that nothing was strobed. The address wrap from 0x7FF to 0x000 also needs setup. The bench does a dummy write to block 7, word 0xFF, then a repeated START into a read of two bytes.

// File: rtl/ee_i2c_pkg.sv
package ee_i2c_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_WADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK
  } ee_state_e;
endpackage

// File: rtl/ee_bus_edges.sv
module ee_bus_edges (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
  // data edges qualified by SCL high on both samples
  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
endmodule

// File: rtl/ee_addr_ctr.sv
module ee_addr_ctr #(
  parameter int ADDR_W = 11,
  parameter int BLK_W  = 3,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_blk_i,
  input  logic [BLK_W-1:0]  blk_i,
  input  logic              ld_word_i,
  input  logic [ADDR_W-BLK_W-1:0] word_i,
  input  logic              inc_page_i,
  input  logic              inc_full_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int WORD_W = ADDR_W - BLK_W;

  logic [ADDR_W-1:0] addr_q, page_next;

  generate
    if (PAGE_W < ADDR_W) begin : g_page
      assign page_next = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PAGE_W'(1)};
    end else begin : g_flat
      assign page_next = addr_q + ADDR_W'(1);
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (inc_full_i) begin
      addr_q <= addr_q + ADDR_W'(1);
    end else if (inc_page_i) begin
      addr_q <= page_next;
    end else begin
      if (ld_blk_i)  addr_q[ADDR_W-1 -: BLK_W] <= blk_i;
      if (ld_word_i) addr_q[WORD_W-1:0]        <= word_i;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/ee_i2c_front.sv
module ee_i2c_front
  import ee_i2c_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int BLK_W  = 3,
  parameter int PAGE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              busy_i,
  input  logic              wp_i,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              wr_commit_o,
  output logic              rd_en_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i
);
  localparam int WORD_W = ADDR_W - BLK_W;

  logic scl_rise, scl_fall, start_det, stop_det;
  ee_state_e state_q, after_q;
  logic [3:0] cnt_q;
  logic [7:0] sh_q;
  logic oe_q, mack_q, pend_q;
  logic wr_valid_q, commit_q, rd_en_q;
  logic [ADDR_W-1:0] wr_addr_q, addr;
  logic [7:0] wr_data_q;
  logic byte_end, dev_hit, ld_blk, ld_word, inc_page, rd_load;
  logic in_idle;

  ee_bus_edges u_edges (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (scl_i),
    .sda_i      (sda_i),
    .scl_rise_o (scl_rise),
    .scl_fall_o (scl_fall),
    .start_o    (start_det),
    .stop_o     (stop_det)
  );

  always_comb begin
    byte_end = scl_fall && (cnt_q == 4'd8);
    dev_hit  = (sh_q[7:4] == DEV_CODE) && !busy_i;
    ld_blk   = 1'b0;
    ld_word  = 1'b0;
    inc_page = 1'b0;
    rd_load  = 1'b0;
    if (!start_det && !stop_det) begin
      ld_blk   = (state_q == ST_DEV) && byte_end && dev_hit;
      ld_word  = (state_q == ST_WADDR) && byte_end;
      inc_page = (state_q == ST_WDATA) && byte_end && !wp_i;
      rd_load  = scl_fall && (((state_q == ST_ACK) && (after_q == ST_RDATA)) ||
                              ((state_q == ST_RACK) && mack_q));
    end
  end

  ee_addr_ctr #(
    .ADDR_W (ADDR_W),
    .BLK_W  (BLK_W),
    .PAGE_W (PAGE_W)
  ) u_addr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ld_blk_i   (ld_blk),
    .blk_i      (sh_q[BLK_W:1]),
    .ld_word_i  (ld_word),
    .word_i     (sh_q[WORD_W-1:0]),
    .inc_page_i (inc_page),
    .inc_full_i (rd_load),
    .addr_o     (addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      after_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      oe_q       <= 1'b0;
      mack_q     <= 1'b0;
      pend_q     <= 1'b0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      commit_q   <= 1'b0;
      rd_en_q    <= 1'b0;
    end else begin
      wr_valid_q <= 1'b0;
      commit_q   <= 1'b0;
      rd_en_q    <= 1'b0;
      if (start_det) begin
        state_q <= ST_DEV;
        cnt_q   <= '0;
        oe_q    <= 1'b0;
      end else if (stop_det) begin
        state_q  <= ST_IDLE;
        cnt_q    <= '0;
        oe_q     <= 1'b0;
        commit_q <= pend_q;
        pend_q   <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_WADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 4'd1;
            end
            if (byte_end) begin
              cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (dev_hit) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                  after_q <= sh_q[0] ? ST_RDATA : ST_WADDR;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_WADDR) begin
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
                after_q <= ST_WDATA;
              end else begin
                state_q <= ST_ACK;
                after_q <= ST_WDATA;
                if (!wp_i) begin
                  oe_q       <= 1'b1;
                  wr_valid_q <= 1'b1;
                  wr_addr_q  <= addr;
                  wr_data_q  <= sh_q;
                  pend_q     <= 1'b1;
                end
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (after_q == ST_RDATA) begin
                sh_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
                rd_en_q <= 1'b1;
                state_q <= ST_RDATA;
              end else begin
                oe_q    <= 1'b0;
                state_q <= after_q;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) cnt_q <= cnt_q + 4'd1;
            if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                oe_q    <= 1'b0;
                cnt_q   <= '0;
                state_q <= ST_RACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_i;
            if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                sh_q    <= rd_data_i;
                oe_q    <= ~rd_data_i[7];
                rd_en_q <= 1'b1;
                state_q <= ST_RDATA;
              end else begin
                oe_q    <= 1'b0;
                state_q <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign in_idle     = (state_q == ST_IDLE);
  assign sda_oe_o    = oe_q;
  assign wr_valid_o  = wr_valid_q;
  assign wr_addr_o   = wr_addr_q;
  assign wr_data_o   = wr_data_q;
  assign wr_commit_o = commit_q;
  assign rd_en_o     = rd_en_q;
  assign rd_addr_o   = addr;
endmodule

// File: rtl/ee_i2c_front_chk.sv
module ee_i2c_front_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic scl_i,
  input logic wp_i,
  input logic sda_oe_o,
  input logic wr_valid_o,
  input logic wr_commit_o,
  input logic in_idle
);
  p_drive_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> !$past(scl_i));

  p_release_scl_low_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sda_oe_o) && !in_idle |-> !$past(scl_i));

  p_no_store_wp_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> !$past(wp_i));

  p_single_strobe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  p_commit_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_commit_o |=> !wr_commit_o);

  p_idle_released_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_idle |-> !sda_oe_o);
endmodule

bind ee_i2c_front ee_i2c_front_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .scl_i       (scl_i),
  .wp_i        (wp_i),
  .sda_oe_o    (sda_oe_o),
  .wr_valid_o  (wr_valid_o),
  .wr_commit_o (wr_commit_o),
  .in_idle     (in_idle)
);

// File: tb/ee_i2c_front_bench.sv
`timescale 1ns/1ps
module ee_i2c_front_bench;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic busy = 1'b0, wp = 1'b0;
  logic sda_oe, wr_valid, wr_commit, rd_en;
  logic [10:0] wr_addr, rd_addr;
  logic [7:0] wr_data;
  logic [7:0] mem [2048];
  logic sda_bus;

  int checks = 0, errors = 0;
  int wr_n = 0, commit_n = 0, r12_viol = 0;
  logic [10:0] log_addr [16];
  logic [7:0]  log_data [16];
  logic oe_prev = 1'b0, scl_prev = 1'b1;

  always #4 clk = ~clk;

  assign sda_bus = m_sda & ~sda_oe;

  ee_i2c_front u_ee_i2c_front (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .scl_i       (m_scl),
    .sda_i       (sda_bus),
    .sda_oe_o    (sda_oe),
    .busy_i      (busy),
    .wp_i        (wp),
    .wr_valid_o  (wr_valid),
    .wr_addr_o   (wr_addr),
    .wr_data_o   (wr_data),
    .wr_commit_o (wr_commit),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .rd_data_i   (mem[rd_addr])
  );

  function automatic logic [7:0] init_val(int a);
    return 8'(a * 7 + 3);
  endfunction

  always @(negedge clk) begin
    if (rst_ni) begin
      if (wr_valid) begin
        if (wr_n < 16) begin
          log_addr[wr_n] = wr_addr;
          log_data[wr_n] = wr_data;
        end
        mem[wr_addr] = wr_data;
        wr_n++;
      end
      if (wr_commit) commit_n++;
      if (sda_oe != oe_prev && m_scl && scl_prev) r12_viol++;
    end
    oe_prev  = sda_oe;
    scl_prev = m_scl;
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wt();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wt(); m_scl = 1'b1; wt(); m_sda = 1'b0; wt(); m_scl = 1'b0; wt();
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wt(); m_scl = 1'b1; wt(); m_sda = 1'b1; wt();
  endtask

  task automatic send_bit(input logic b);
    m_sda = b; wt(); m_scl = 1'b1; wt(); wt(); m_scl = 1'b0; wt();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wt(); m_scl = 1'b1; wt();
    ack = ~sda_bus;
    wt(); m_scl = 1'b0; wt();
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wt(); m_scl = 1'b1; wt();
      b[i] = sda_bus;
      wt(); m_scl = 1'b0;
    end
    m_sda = ~give_ack; wt(); m_scl = 1'b1; wt(); wt(); m_scl = 1'b0; wt();
    m_sda = 1'b1;
  endtask

  task automatic t_reset();
    chk(sda_oe == 1'b0, "R13 sda released", sda_oe, 0);
    chk(wr_valid == 1'b0 && wr_commit == 1'b0, "R13 strobes low", {wr_valid, wr_commit}, 0);
  endtask

  task automatic t_bad_code();
    logic a;
    int w0 = wr_n;
    bus_start();
    send_byte(8'hB0, a);
    chk(!a, "R1 foreign code nack", a, 0);
    send_byte(8'h00, a);
    chk(!a, "R1 following byte ignored", a, 0);
    bus_stop(); wt();
    chk(wr_n == w0, "R1 no store", wr_n, w0);
  endtask

  task automatic t_page_write();
    logic a;
    int w0 = wr_n, c0 = commit_n;
    bus_start();
    send_byte(8'hA6, a); chk(a, "R3 write device ack", a, 1);
    send_byte(8'h1E, a); chk(a, "R4 word ack", a, 1);
    send_byte(8'h11, a); chk(a, "R5 data ack", a, 1);
    send_byte(8'h22, a); chk(a, "R5 data ack 2", a, 1);
    send_byte(8'h33, a); chk(a, "R5 data ack 3", a, 1);
    chk(wr_n == w0 + 3, "R5 strobe count", wr_n, w0 + 3);
    chk(log_addr[w0] == 11'h31E && log_data[w0] == 8'h11, "R5 first strobe", log_addr[w0], 11'h31E);
    chk(log_addr[w0+1] == 11'h31F && log_data[w0+1] == 8'h22, "R6 second strobe", log_addr[w0+1], 11'h31F);
    chk(log_addr[w0+2] == 11'h300 && log_data[w0+2] == 8'h33, "R6 page wrap", log_addr[w0+2], 11'h300);
    chk(commit_n == c0, "R10 no commit before stop", commit_n, c0);
    bus_stop(); wt();
    chk(commit_n == c0 + 1, "R10 commit at stop", commit_n, c0 + 1);
  endtask

  task automatic t_busy();
    logic a;
    busy = 1'b1;
    bus_start();
    send_byte(8'hA0, a);
    chk(!a, "R2 busy nack", a, 0);
    bus_stop();
    busy = 1'b0;
  endtask

  task automatic t_wp();
    logic a;
    logic [7:0] d;
    int w0 = wr_n, c0 = commit_n;
    wp = 1'b1;
    bus_start();
    send_byte(8'hA2, a); chk(a, "R7 device ack", a, 1);
    send_byte(8'h05, a); chk(a, "R7 word ack", a, 1);
    send_byte(8'h5A, a); chk(!a, "R7 data nack", a, 0);
    bus_stop(); wt();
    chk(wr_n == w0, "R7 no strobe", wr_n, w0);
    chk(commit_n == c0, "R10 no commit without data", commit_n, c0);
    wp = 1'b0;
    bus_start();
    send_byte(8'hA3, a);
    recv_byte(1'b0, d);
    chk(d == init_val(11'h105), "R7 address not advanced", d, init_val(11'h105));
    bus_stop();
  endtask

  task automatic t_read(input logic [7:0] dev_w, input logic [7:0] word, input int base, input int n);
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(dev_w, a);
    send_byte(word, a);
    bus_start();
    send_byte(dev_w | 8'h01, a);
    chk(a, "R3 read device ack", a, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      chk(d == init_val((base + i) % 2048), "R8 read byte", d, init_val((base + i) % 2048));
    end
    wt();
    chk(sda_oe == 1'b0, "R9 released after nack", sda_oe, 0);
    bus_stop();
  endtask

  task automatic t_abort();
    logic a;
    logic [7:0] d;
    int w0 = wr_n;
    bus_start();
    send_byte(8'hA4, a);
    send_byte(8'h10, a);
    send_bit(1'b1); send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(8'hA5, a);
    recv_byte(1'b0, d);
    chk(d == init_val(11'h210), "R11 restart discards partial", d, init_val(11'h210));
    bus_stop();
    bus_start();
    send_byte(8'hA4, a);
    send_byte(8'h20, a);
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b1);
    bus_stop();
    bus_start();
    send_byte(8'hA5, a);
    recv_byte(1'b0, d);
    chk(d == init_val(11'h220), "R11 stop discards partial", d, init_val(11'h220));
    bus_stop(); wt();
    chk(wr_n == w0, "R11 no strobe", wr_n, w0);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = init_val(i);
    repeat (5) @(negedge clk);
    t_reset();
    rst_ni = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_bad_code();
    t_page_write();
    t_busy();
    t_wp();
    t_read(8'hAA, 8'hFE, 11'h5FE, 3);
    t_read(8'hAE, 8'hFF, 11'h7FF, 2);
    t_abort();
    chk(r12_viol == 0, "R12 sda change with scl high", r12_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule